// File: doc/BRIEF.md
# Two-Stage Fetch/Execute Instruction Sequencer

This block sequences instructions for a small processor with a separate program memory and data memory. It holds a 16-bit program counter, drives the address of a combinational program-memory read port, and captures the returned 16-bit word in an instruction register. Because the instruction register is loaded while the next word is being addressed, the fetch of one instruction overlaps the execution of the one before it, and a straight-line instruction completes every cycle.

An external decoder looks at the presented instruction and reports its class: ordinary, change of flow (a taken branch or any write to the program counter), or a transfer between program memory and data memory. A change of flow loads the program counter from the supplied target and discards the word already fetched, so one bubble follows. A transfer borrows the program bus for one extra cycle: the bus is then addressed by a table pointer input, and the program counter and instruction register hold. An instruction retires in a cycle where `ex_valid` is high and `ex_stall` is low.

Top module: `instr_seq`

## Requirements
- R1: While reset is active and in the first cycle after it, `ex_valid` is low, `ex_stall` and `ex_flush` are low, and the program bus is addressed at 0x0000; the instruction at 0x0000 is presented in the second cycle after reset.
- R2: With ordinary instructions (class code 2'b00, and 2'b11 treated the same), one instruction retires per cycle and each retired address is the previous retired address plus one.
- R3: The presented word `ex_instr` is the word the program bus returned for address `ex_pc` in the cycle it was fetched.
- R4: A change-of-flow instruction (class code 2'b01) raises `ex_flush` in its cycle; the next cycle has `ex_valid` low, and the instruction at `ex_target` retires two cycles after the change-of-flow instruction retired.
- R5: A transfer instruction (class code 2'b10) raises `ex_stall` for exactly one cycle; in that cycle `pbus_addr` equals `tbl_ptr` and `pbus_tbl` is high; the next cycle presents the same instruction with the stall low, so a transfer takes two cycles.
- R6: When `ex_valid` is low, the class and target inputs have no effect on the fetched addresses or the retired sequence.
- R7: The program counter advances from 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pbus_addr | output | 16 | Program-memory read address |
| pbus_tbl | output | 1 | High when the program bus carries a data-transfer access |
| pbus_rdata | input | 16 | Program-memory read data for `pbus_addr`, same cycle |
| ex_class | input | 2 | Class of the presented instruction: 00 ordinary, 01 change of flow, 10 transfer, 11 ordinary |
| ex_target | input | 16 | New program counter value for a change of flow |
| tbl_ptr | input | 16 | Program-memory address used during a transfer |
| ex_instr | output | 16 | Instruction word in the execute stage |
| ex_pc | output | 16 | Address of the instruction in the execute stage |
| ex_valid | output | 1 | Execute stage holds a real instruction |
| ex_stall | output | 1 | Presented instruction is held for one more cycle |
| ex_flush | output | 1 | Fetched next word is discarded this cycle |

## Verification
The sequencer is driven by a decoder model in the bench that classifies each address by a per-scenario rule: all-ordinary code, periodic forward branches, periodic transfers, a mix with a branch near the top of the address space and a transfer at 0xFFFF, and a branch to its own address. Each retired address is checked against the cycle in which it should appear, so the runs separate a missing or extra bubble, a wrong branch destination, a transfer that costs the wrong number of cycles and a missed wrap of the counter. Bubble cycles are fed a change-of-flow class with a bogus target, which shows whether the block wrongly acts on class inputs when nothing is valid.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        CLS_PLAIN = 2'b00,
        CLS_FLOW  = 2'b01,
        CLS_XFER  = 2'b10,
        CLS_ALT   = 2'b11
    } ins_class_e;

    typedef struct packed {
        logic [15:0] pc;
        logic [15:0] ir;
        logic [15:0] ir_pc;
        logic        valid;
        logic        xfer_done;
    } seq_state_t;

endpackage

// File: rtl/seq_pc_inc.sv
module seq_pc_inc #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    // Wraps naturally at the top of the address space.
    always_comb nxt = cur + ONE;
endmodule

// File: rtl/seq_next.sv
module seq_next
    import seq_pkg::*;
(
    input  seq_state_t  st_q,
    input  logic [1:0]  cls,
    input  logic [15:0] target,
    input  logic [15:0] tbl_ptr,
    input  logic [15:0] rdata,
    input  logic [15:0] pc_plus,
    output seq_state_t  st_d,
    output logic [15:0] bus_addr,
    output logic        bus_tbl,
    output logic        stall,
    output logic        flush
);
    ins_class_e kind;

    always_comb begin
        kind  = ins_class_e'(cls);
        stall = st_q.valid && (kind == CLS_XFER) && !st_q.xfer_done;
        flush = st_q.valid && (kind == CLS_FLOW);

        bus_tbl  = stall;
        bus_addr = stall ? tbl_ptr : st_q.pc;

        st_d = st_q;
        if (stall) begin
            st_d.xfer_done = 1'b1;
        end else if (flush) begin
            st_d.pc        = target;
            st_d.valid     = 1'b0;
            st_d.xfer_done = 1'b0;
        end else begin
            st_d.ir        = rdata;
            st_d.ir_pc     = st_q.pc;
            st_d.pc        = pc_plus;
            st_d.valid     = 1'b1;
            st_d.xfer_done = 1'b0;
        end
    end
endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t st_d,
    output seq_state_t st_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc        <= '0;
            st_q.ir        <= '0;
            st_q.ir_pc     <= '0;
            st_q.valid     <= 1'b0;
            st_q.xfer_done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/instr_seq.sv
module instr_seq
    import seq_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] pbus_addr,
    output logic          pbus_tbl,
    input  logic [15:0]   pbus_rdata,
    input  logic [1:0]    ex_class,
    input  logic [AW-1:0] ex_target,
    input  logic [AW-1:0] tbl_ptr,
    output logic [15:0]   ex_instr,
    output logic [AW-1:0] ex_pc,
    output logic          ex_valid,
    output logic          ex_stall,
    output logic          ex_flush
);
    seq_state_t  st_q, st_d;
    logic [15:0] pc_plus;

    seq_pc_inc #(.AW(16)) u_inc (
        .cur (st_q.pc),
        .nxt (pc_plus)
    );

    seq_next u_next (
        .st_q     (st_q),
        .cls      (ex_class),
        .target   (ex_target),
        .tbl_ptr  (tbl_ptr),
        .rdata    (pbus_rdata),
        .pc_plus  (pc_plus),
        .st_d     (st_d),
        .bus_addr (pbus_addr),
        .bus_tbl  (pbus_tbl),
        .stall    (ex_stall),
        .flush    (ex_flush)
    );

    seq_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .st_d  (st_d),
        .st_q  (st_q)
    );

    assign ex_instr = st_q.ir;
    assign ex_pc    = st_q.ir_pc;
    assign ex_valid = st_q.valid;
endmodule

// File: rtl/instr_seq_chk.sv
module instr_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] pbus_addr,
    input logic          pbus_tbl,
    input logic [AW-1:0] tbl_ptr,
    input logic [AW-1:0] ex_pc,
    input logic          ex_valid,
    input logic          ex_stall,
    input logic          ex_flush
);
    // R1: nothing is stalled or flushed without a valid instruction
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_valid |-> (!ex_stall && !ex_flush));

    // R3: a freshly presented instruction came from last cycle's fetch address
    assert_fetch_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !$past(ex_stall) && !$past(pbus_tbl)) |-> ex_pc == $past(pbus_addr));

    // R4: the cycle after a flush is a bubble
    assert_flush_bubble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ex_flush |=> !ex_valid);

    // R5: a stall lasts one cycle and holds the instruction
    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ex_stall |=> (ex_valid && !ex_stall && $stable(ex_pc)));

    // R5: the bus goes to the table pointer only during a stall
    assert_tbl_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pbus_tbl |-> (ex_stall && pbus_addr == tbl_ptr));

    // R2: never both stall and flush
    assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ex_stall && ex_flush));
endmodule

bind instr_seq instr_seq_chk #(.AW(AW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pbus_addr (pbus_addr),
    .pbus_tbl  (pbus_tbl),
    .tbl_ptr   (tbl_ptr),
    .ex_pc     (ex_pc),
    .ex_valid  (ex_valid),
    .ex_stall  (ex_stall),
    .ex_flush  (ex_flush)
);

// File: tb/instr_seq_tb_top.sv
`timescale 1ns/1ps
module instr_seq_tb_top;
    localparam logic [15:0] KEY = 16'hA5C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pbus_addr, pbus_rdata, ex_target, tbl_ptr, ex_instr, ex_pc;
    logic        pbus_tbl, ex_valid, ex_stall, ex_flush;
    logic [1:0]  ex_class;

    int total = 0;
    int bad = 0;
    int sc = 0;
    int cyc = 0;
    int nret = 0;
    int exp_cyc = 1;
    logic [15:0] exp_addr = 16'h0000;
    logic prev_flush = 1'b0;
    logic first_cyc = 1'b0;

    always #4 clk = ~clk;

    instr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .pbus_addr(pbus_addr), .pbus_tbl(pbus_tbl),
        .pbus_rdata(pbus_rdata), .ex_class(ex_class), .ex_target(ex_target),
        .tbl_ptr(tbl_ptr), .ex_instr(ex_instr), .ex_pc(ex_pc), .ex_valid(ex_valid),
        .ex_stall(ex_stall), .ex_flush(ex_flush)
    );

    // Program memory model: word is address xor a key.
    assign pbus_rdata = pbus_addr ^ KEY;

    function automatic logic [1:0] cls_of(int s, logic [15:0] a);
        case (s)
            1: return (a[2:0] == 3'd3) ? 2'b01 : ((a[2:0] == 3'd6) ? 2'b11 : 2'b00);
            2: return (a % 3 == 1) ? 2'b10 : 2'b00;
            3: return (a == 16'd4) ? 2'b01 :
                      ((a == 16'hFFFF || a == 16'd2) ? 2'b10 : 2'b00);
            4: return (a == 16'd6) ? 2'b01 : ((a == 16'd3) ? 2'b10 : 2'b00);
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [15:0] tgt_of(int s, logic [15:0] a);
        case (s)
            3: return 16'hFFFD;
            4: return 16'd6;
            default: return a + 16'd9;
        endcase
    endfunction

    // Decoder model; bubbles get a bogus change of flow (R6).
    always_comb begin
        if (ex_valid) begin
            ex_class  = cls_of(sc, ex_pc);
            ex_target = tgt_of(sc, ex_pc);
        end else begin
            ex_class  = 2'b01;
            ex_target = 16'h1234;
        end
        tbl_ptr = 16'hC000 | ex_pc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (sc=%0d cyc=%0d)",
                     req, what, act, exp, sc, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            exp_addr   = 16'h0000;
            exp_cyc    = 1;
            nret       = 0;
            prev_flush = 1'b0;
            first_cyc  = 1'b1;
        end else begin
            if (first_cyc) begin
                check(!ex_valid && !ex_stall && !ex_flush, "R1", "first cycle idle",
                      {ex_valid, ex_stall, ex_flush}, 0);
                check(pbus_addr == 16'h0000, "R1", "first fetch address", pbus_addr, 0);
                first_cyc = 1'b0;
            end
            if (prev_flush)
                check(!ex_valid, "R4", "bubble after flush", ex_valid, 0);
            prev_flush = ex_flush;
            if (ex_stall) begin
                check(pbus_tbl && pbus_addr == (16'hC000 | ex_pc), "R5",
                      "table access on stall", {pbus_tbl, pbus_addr}, {1'b1, 16'hC000 | ex_pc});
                check(ex_pc == exp_addr && cls_of(sc, exp_addr) == 2'b10, "R5",
                      "stall only on transfer", ex_pc, exp_addr);
            end
            if (ex_valid && !ex_stall) begin
                check(ex_pc == exp_addr, "R2/R4/R6/R7", "retired address", ex_pc, exp_addr);
                check(cyc == exp_cyc, "R2/R4/R5", "retire cycle", cyc, exp_cyc);
                check(ex_instr == (exp_addr ^ KEY), "R3", "instruction word",
                      ex_instr, exp_addr ^ KEY);
                nret++;
                case (cls_of(sc, exp_addr))
                    2'b01: begin exp_addr = tgt_of(sc, exp_addr); exp_cyc += 2; end
                    default: begin exp_addr = exp_addr + 16'd1; exp_cyc += 1; end
                endcase
                // a transfer retires one cycle late; account for its start
                if (cls_of(sc, exp_addr) == 2'b10) exp_cyc += 1;
            end
        end
    end

    initial begin
        for (int s = 0; s < 5; s++) begin
            @(negedge clk);
            rst_n = 1'b0;
            sc = s;
            repeat (3) @(negedge clk);
            check(!ex_valid && !ex_stall && !ex_flush && pbus_addr == 16'h0000, "R1",
                  "reset state", {ex_valid, ex_stall, ex_flush, pbus_addr}, 0);
            rst_n = 1'b1;
            repeat (60) @(negedge clk);
            check(nret >= 20, "R2", "enough retirements", nret, 20);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule